// File: doc/BRIEF.md
# Variable-Accept Issue Link

This block is the source side of a link between a queue of pending entries and a consumer stage that may take any number of them in a cycle. In every cycle the source shows its oldest stored entries on a set of offer lanes. It shows as many as it holds, up to the lane count. The valid mask is thermometer-coded, and lane 0 always carries the oldest entry. In the same cycle the consumer answers with an accept count. The source then removes exactly that many entries from the front of its queue. In the next cycle it shows the entries that were not taken, still oldest first, followed by newer ones.

New entries come in on a set of input lanes with a per-lane valid mask, which may be sparse. The valid lanes are packed together in ascending lane order and appended behind the stored entries. Input is taken only while the queue has room for a full set of input lanes. This condition is reported to the producer, so the producer never has to know how many entries are held. An accept count larger than the number of offered entries is flagged and limited to that number.

Top module: `mimo_link`

## Requirements
- R1: While reset is held and after it is released, the link shows no valid offer lane (`offer_valid` is all zero) and reports room for input (`in_room` = 1).
- R2: `offer_valid` is thermometer-coded. Lanes 0 to k−1 are set, where k = min(number of stored entries, OUT_LANES).
- R3: Offer lane i carries the i-th oldest stored entry in arrival order. Lane 0 carries the oldest.
- R4: An accept count a (a ≤ k) removes the first a offered entries. In the next cycle, lane 0 carries the entry that was on lane a.
- R5: An accept count of 0 leaves the stored entries unchanged. Without new input, the next cycle shows the same mask and data.
- R6: When `accept_cnt` > k, `accept_over` is 1 in the same cycle and exactly k entries are removed. Otherwise `accept_over` is 0.
- R7: Input lanes with `in_valid[i]` = 0 are ignored. The valid input lanes are appended in ascending lane order, so input lane 1 is stored behind input lane 0.
- R8: `in_room` is 1 exactly when stored entries + IN_LANES ≤ DEPTH, counted before this cycle's accept. While `in_room` is 0, input is ignored. The queue never holds more than DEPTH entries.
- R9: Under arbitrary accept counts, every entry that is pushed is accepted exactly once, in push order.
- R10: An accept and a push in the same cycle both take effect. The next cycle shows the remaining old entries followed by the new ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | IN_LANES | Per-lane valid for new entries, may be sparse |
| in_data | input | IN_LANES*W | New entry data, lane i at bits [i*W +: W] |
| in_room | output | 1 | Queue can take a full set of input lanes this cycle |
| offer_valid | output | OUT_LANES | Thermometer mask of offered lanes |
| offer_data | output | OUT_LANES*W | Offered entries, lane 0 oldest |
| accept_cnt | input | ACC_W | Number of offered entries the consumer takes this cycle |
| accept_over | output | 1 | Accept count exceeded the offered count and was limited |

## Verification
`offer_valid`, `offer_data` and `in_room` come straight from the stored queue state, and `accept_over` is combinational from `accept_cnt`. All four are therefore due in the same cycle that inputs are applied. The bench drives inputs at the falling edge and samples these outputs 1 ns later. The effect of an accept or a push lands on the next rising edge, so the bench updates its queue model at that edge and compares the resulting offer in the following cycle. Accepted entries are scored against a running push sequence number, taken from the lanes captured before the edge.

// File: rtl/mimo_link_pkg.sv
// Package: shared helpers for the variable-accept issue link.
// Assumes integer arguments fit in 32 bits.
package mimo_link_pkg;

    // Smaller of two integers, used for lane count limits.
    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/mimo_lane_compactor.sv
// Lane compactor: packs the valid lanes of a sparse input group into
// the lowest output lanes, keeping ascending lane order.
// Assumes: purely combinational; invalid output lanes read as zero.
module mimo_lane_compactor #(
    parameter int W     = 8,
    parameter int LANES = 4,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]   in_valid,
    input  logic [LANES*W-1:0] in_data,
    output logic [LANES-1:0]   out_valid,
    output logic [LANES*W-1:0] out_data,
    output logic [CNT_W-1:0]   out_cnt
);

    int pos;

    // Walk the input lanes and place each valid one at the next free slot.
    always_comb begin
        out_data = '0;
        pos = 0;
        for (int i = 0; i < LANES; i++) begin
            if (in_valid[i]) begin
                out_data[pos*W +: W] = in_data[i*W +: W];
                pos = pos + 1;
            end
        end
        out_cnt = CNT_W'(pos);
    end

    // Thermometer mask of packed lanes.
    for (genvar j = 0; j < LANES; j++) begin : g_vld
        assign out_valid[j] = (int'(out_cnt) > j);
    end

endmodule

// File: rtl/mimo_offer_window.sv
// Offer window: presents the oldest stored entries of a ring on the
// offer lanes, lane 0 at the ring head, with a thermometer valid mask.
// Assumes: DEPTH is a power of two so pointer arithmetic wraps freely.
module mimo_offer_window #(
    parameter int W     = 8,
    parameter int LANES = 4,
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int LVL_W = $clog2(DEPTH + 1),
    parameter int ACC_W = $clog2(LANES + 1)
) (
    input  logic [DEPTH*W-1:0] store,
    input  logic [PTR_W-1:0]   head,
    input  logic [LVL_W-1:0]   level,
    output logic [LANES-1:0]   offer_valid,
    output logic [LANES*W-1:0] offer_data,
    output logic [ACC_W-1:0]   offer_cnt
);

    // Number of lanes shown: stored entries limited by the lane count.
    assign offer_cnt = ACC_W'(mimo_link_pkg::min_int(int'(level), LANES));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [PTR_W-1:0] rd_idx;
        // Ring slot of the i-th oldest entry.
        assign rd_idx = head + PTR_W'(i);
        assign offer_data[i*W +: W] = store[rd_idx*W +: W];
        assign offer_valid[i] = (int'(level) > i);
    end

endmodule

// File: rtl/mimo_accept_clamp.sv
// Accept clamp: limits the consumer's accept count to the number of
// offered lanes and flags any excess.
// Assumes: both counts are unsigned and combinational.
module mimo_accept_clamp #(
    parameter int ACC_W = 3
) (
    input  logic [ACC_W-1:0] accept_cnt,
    input  logic [ACC_W-1:0] offer_cnt,
    output logic [ACC_W-1:0] eff_cnt,
    output logic             over
);

    // Compare once and choose the smaller count.
    always_comb begin
        over    = (accept_cnt > offer_cnt);
        eff_cnt = over ? offer_cnt : accept_cnt;
    end

endmodule

// File: rtl/mimo_link.sv
// Variable-accept issue link (top): a ring of DEPTH entries filled from
// sparse input lanes and drained by a same-cycle accept count.
// Assumes: DEPTH is a power of two, IN_LANES <= DEPTH, OUT_LANES <= DEPTH,
// and ACC_W can encode OUT_LANES.
module mimo_link #(
    parameter int W         = 8,
    parameter int IN_LANES  = 4,
    parameter int OUT_LANES = 4,
    parameter int DEPTH     = 8,
    parameter int ACC_W     = $clog2(OUT_LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IN_LANES-1:0]     in_valid,
    input  logic [IN_LANES*W-1:0]   in_data,
    output logic                    in_room,
    output logic [OUT_LANES-1:0]    offer_valid,
    output logic [OUT_LANES*W-1:0]  offer_data,
    input  logic [ACC_W-1:0]        accept_cnt,
    output logic                    accept_over
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int INC_W = $clog2(IN_LANES + 1);

    if (DEPTH != (1 << PTR_W)) begin : g_depth_check
        $error("mimo_link: DEPTH must be a power of two");
    end

    logic [DEPTH*W-1:0]     store_q;
    logic [PTR_W-1:0]       head_q;
    logic [LVL_W-1:0]       level_q;
    logic [IN_LANES-1:0]    c_valid;
    logic [IN_LANES*W-1:0]  c_data;
    logic [INC_W-1:0]       c_cnt;
    logic [ACC_W-1:0]       offer_cnt;
    logic [ACC_W-1:0]       eff_cnt;
    logic [INC_W-1:0]       push_cnt;
    logic [PTR_W-1:0]       tail;
    logic [IN_LANES-1:0]    wr_en;
    logic [PTR_W-1:0]       wr_idx [IN_LANES];

    mimo_lane_compactor #(.W(W), .LANES(IN_LANES), .CNT_W(INC_W)) i_compact (
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (c_valid),
        .out_data  (c_data),
        .out_cnt   (c_cnt)
    );

    mimo_offer_window #(.W(W), .LANES(OUT_LANES), .DEPTH(DEPTH),
                        .PTR_W(PTR_W), .LVL_W(LVL_W), .ACC_W(ACC_W)) i_window (
        .store       (store_q),
        .head        (head_q),
        .level       (level_q),
        .offer_valid (offer_valid),
        .offer_data  (offer_data),
        .offer_cnt   (offer_cnt)
    );

    mimo_accept_clamp #(.ACC_W(ACC_W)) i_clamp (
        .accept_cnt (accept_cnt),
        .offer_cnt  (offer_cnt),
        .eff_cnt    (eff_cnt),
        .over       (accept_over)
    );

    // Room check uses the level before this cycle's accept.
    assign in_room  = (int'(level_q) + IN_LANES) <= DEPTH;
    assign push_cnt = in_room ? c_cnt : '0;
    assign tail     = head_q + PTR_W'(level_q);

    for (genvar j = 0; j < IN_LANES; j++) begin : g_wr
        // Slot and enable for the j-th packed input entry.
        assign wr_idx[j] = tail + PTR_W'(j);
        assign wr_en[j]  = in_room && (int'(c_cnt) > j);
    end

    // Write packed input entries behind the stored ones.
    always_ff @(posedge clk) begin
        for (int j = 0; j < IN_LANES; j++) begin
            if (wr_en[j]) begin
                store_q[wr_idx[j]*W +: W] <= c_data[j*W +: W];
            end
        end
    end

    // Advance head by the accepted count and update the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            level_q <= '0;
        end else begin
            head_q  <= head_q + PTR_W'(eff_cnt);
            level_q <= level_q - LVL_W'(eff_cnt) + LVL_W'(push_cnt);
        end
    end

    AST_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        ((offer_valid & (offer_valid + 1'b1)) == '0)); // R2

    AST_HOLD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_cnt == '0 && !(in_room && |in_valid))
        |=> ($stable(offer_valid) && $stable(offer_data))); // R5

    if (OUT_LANES >= 2) begin : g_shift_chk
        AST_SHIFT_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (accept_cnt == ACC_W'(1) && offer_valid[1])
            |=> (offer_data[W-1:0] == $past(offer_data[2*W-1:W]))); // R4
    end

    AST_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        accept_over |-> (int'(accept_cnt) > $countones(offer_valid))); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level_q) <= DEPTH)); // R8

    AST_ROOM_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !in_room |=> (level_q <= $past(level_q))); // R8

    AST_COMPACT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(c_valid) == $countones(in_valid))); // R7

endmodule

// File: tb/test_mimo_link.sv
// Bench for mimo_link: directed cases, then a sweep of every input mask
// against every accept count, scored against a queue model.
module test_mimo_link;

    localparam int W = 8, IL = 4, OL = 4, DEPTH = 8, ACC_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IL-1:0]   in_valid = '0;
    logic [IL*W-1:0] in_data = '0;
    logic            in_room;
    logic [OL-1:0]   offer_valid;
    logic [OL*W-1:0] offer_data;
    logic [ACC_W-1:0] accept_cnt = '0;
    logic            accept_over;

    int checks = 0, errors = 0;
    int q[$];
    int push_seq = 0, acc_seq = 0;

    always #2 clk = ~clk;

    mimo_link #(.W(W), .IN_LANES(IL), .OUT_LANES(OL), .DEPTH(DEPTH), .ACC_W(ACC_W)) i_mimo_link (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_room(in_room), .offer_valid(offer_valid), .offer_data(offer_data),
        .accept_cnt(accept_cnt), .accept_over(accept_over)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, check 1 ns later, update model at rising edge.
    task automatic step(input logic [IL-1:0] mask, input int acc, input string tag);
        int k, eff, s;
        bit room;
        logic [OL*W-1:0] snap;
        @(negedge clk);
        s = push_seq;
        for (int i = 0; i < IL; i++) begin
            if (mask[i]) begin
                in_data[i*W +: W] = W'(s);
                s++;
            end else begin
                in_data[i*W +: W] = W'(8'hA5 ^ i);
            end
        end
        in_valid = mask;
        accept_cnt = ACC_W'(acc);
        #1;
        k = (q.size() < OL) ? q.size() : OL;
        chk(tag, int'(offer_valid), (1 << k) - 1);
        for (int i = 0; i < k; i++) chk(tag, int'(offer_data[i*W +: W]), q[i]);
        room = (q.size() + IL) <= DEPTH;
        chk("R8", int'(in_room), int'(room));
        chk("R6", int'(accept_over), int'(acc > k));
        snap = offer_data;
        @(posedge clk);
        eff = (acc < k) ? acc : k;
        for (int i = 0; i < eff; i++) begin
            chk("R9", int'(snap[i*W +: W]), acc_seq & 255);
            acc_seq++;
            void'(q.pop_front());
        end
        if (room) begin
            for (int i = 0; i < IL; i++) begin
                if (mask[i]) begin
                    q.push_back(push_seq & 255);
                    push_seq++;
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", int'(offer_valid), 0);
        chk("R1", int'(in_room), 1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", int'(offer_valid), 0);
        chk("R1", int'(in_room), 1);

        step(4'b0101, 0, "R7");   // sparse push of two entries
        step(4'b1111, 0, "R7");   // compacted pair shown, four more pushed
        step(4'b0000, 0, "R5");   // six stored, nothing taken
        step(4'b0000, 0, "R5");   // same offer again
        step(4'b0000, 2, "R4");
        step(4'b0000, 3, "R4");   // front moved by two, then three
        step(4'b1111, 1, "R10");  // accept and push together
        step(4'b1111, 0, "R8");   // level 4 + 4 fills the ring
        step(4'b1111, 0, "R8");   // full: push ignored
        step(4'b0000, 7, "R6");   // over-accept limited to four
        step(4'b0000, 7, "R6");
        step(4'b0000, 7, "R6");   // empty, over-accept flagged

        for (int rep = 0; rep < 4; rep++)
            for (int m = 0; m < 16; m++)
                for (int a = 0; a < 8; a++)
                    step(IL'(m ^ rep), (a + rep) % 8, "R3");

        repeat (6) step(4'b0000, 4, "R9");
        chk("R9", acc_seq, push_seq);
        chk("R9", q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule